// File: doc/BRIEF.md
# Signed Two's Complement Array Multiplier

This block multiplies two signed N-bit operands and delivers the full 2N-bit two's complement product. It is built from a grid of AND-gate partial-product bits summed by rows of ripple-carry adder cells, so the worst-case path runs through about 2N adder delays. It does not sign-extend the partial-product rows or subtract the last row.

Signs are handled by rearranging the array. Some partial-product bits are inverted: those that combine the top bit of one operand with a lower bit of the other. Two constant ones are then added, one in column N and one in column 2N-1. With this change the signed array needs about the same hardware as an unsigned one. Any carry out of the top column is dropped, so the result is the product modulo 2^(2N).

A parameter selects one of two output modes. In registered mode the product is captured in an output register. In combinational mode the product is driven straight from the array.

Top module: `bw_mult`

## Requirements
- R1: For every pair of operands in the signed N-bit range, `product` equals the two's complement product of `opA` and `opB`, with the most significant bit of each operand weighted -2^(N-1).
- R2: When both operands are the most negative value, -2^(N-1), `product` is +2^(2N-2): bit 2N-2 is set and every other bit is clear, including the sign bit 2N-1.
- R3: When both operands are nonzero, bit 2N-1 of `product` equals the XOR of `opA[N-1]` and `opB[N-1]`.
- R4: When either operand is zero, `product` is all zeros.
- R5: When `opB` is -1 (all ones), `product` is the 2N-bit negation of the sign-extended `opA`. For `opA` = -2^(N-1) this gives +2^(N-1).
- R6: With REG_OUT=1, `product` changes only at a rising clock edge and shows the value for the operands sampled at that edge. Between edges it keeps its previous value.
- R7: With REG_OUT=1, a high `rst` sampled at a rising edge clears `product` to zero, and `product` stays zero while `rst` remains high.
- R8: With REG_OUT=0, `product` follows the operands without waiting for a clock edge, and `rst` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous, active-high reset of the output register |
| opA | input | N | Signed multiplicand |
| opB | input | N | Signed multiplier |
| product | output | 2N | Signed product, modulo 2^(2N) |

## Verification
The assertions check on every clock the value rules that tie the array sum to the operands:
- the product itself, against a reference product;
- the sign rule for nonzero operands;
- a zero result whenever an operand is zero;
- the square of the most negative value;
- in registered mode, the cleared register in the cycle after a reset.

Some behaviours only the bench scenarios can show. These are the exhaustive sweep at N=4 and the negation by -1. They also include the hold between edges in registered mode and the immediate response with reset asserted in combinational mode. These checks depend on when the bench samples relative to its own stimulus.

// File: rtl/bw_mult_pkg.sv
`timescale 1ns/1ps
package bw_mult_pkg;

  // Strobes from the output control to the datapath register.
  typedef struct packed {
    logic clearOut;
    logic loadOut;
  } outStrobe_t;

  // A partial-product bit is inverted when exactly one of its two factors
  // is an operand sign bit (row = opB index, col = opA index).
  function automatic logic ppInvert(input int row, input int col, input int width);
    return ((row == width - 1) != (col == width - 1));
  endfunction

endpackage

// File: rtl/bw_fa_cell.sv
`timescale 1ns/1ps
module bw_fa_cell (
  input  logic inA,
  input  logic inB,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);
  assign sumOut   = inA ^ inB ^ carryIn;
  assign carryOut = (inA & inB) | (carryIn & (inA ^ inB));
endmodule

// File: rtl/bw_ctrl.sv
`timescale 1ns/1ps
module bw_ctrl
  import bw_mult_pkg::*;
(
  input  logic       rst,
  output outStrobe_t strobe
);
  // The register clears on reset and captures on every other edge.
  always_comb begin
    strobe.clearOut = rst;
    strobe.loadOut  = ~rst;
  end
endmodule

// File: rtl/bw_datapath.sv
`timescale 1ns/1ps
module bw_datapath
  import bw_mult_pkg::*;
#(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  outStrobe_t     strobe,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;
  localparam logic [N-1:0] MIN_VAL = {1'b1, {(N-1){1'b0}}};
  localparam logic [W-1:0] MIN_SQ  = {2'b01, {(W-2){1'b0}}};

  logic [N-1:0] ppRow [N];
  logic [W-1:0] accum [N];

  // Partial-product grid: one AND per bit, sign cross terms inverted (R1).
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam logic INV = ppInvert(r, c, N);
      assign ppRow[r][c] = (opA[c] & opB[r]) ^ INV;
    end
  end

  // Row 0 together with the two constant ones in columns N and W-1.
  assign accum[0] = W'(ppRow[0]) | (W'(1) << N) | (W'(1) << (W - 1));

  // Ripple-carry rows. The carry out of the top column is discarded.
  for (genvar r = 1; r < N; r++) begin : g_add
    logic [W-1:0] addend;
    logic [W-1:0] carry;
    assign addend   = W'(ppRow[r]) << r;
    assign carry[0] = 1'b0;
    for (genvar c = 0; c < W; c++) begin : g_cell
      if (c < W - 1) begin : g_fa
        bw_fa_cell u_fa (
          .inA     (accum[r-1][c]),
          .inB     (addend[c]),
          .carryIn (carry[c]),
          .sumOut  (accum[r][c]),
          .carryOut(carry[c+1])
        );
      end else begin : g_top
        assign accum[r][c] = accum[r-1][c] ^ addend[c] ^ carry[c];
      end
    end
  end

  logic [W-1:0] arraySum;
  assign arraySum = accum[N-1];

  if (REG_OUT) begin : g_reg
    logic [W-1:0] prodQ;
    logic         clearSeen;
    always_ff @(posedge clk) begin
      if (strobe.clearOut)     prodQ <= '0;
      else if (strobe.loadOut) prodQ <= arraySum;
      clearSeen <= strobe.clearOut;
    end
    assign product = prodQ;

    // R7: a reset edge leaves the register cleared.
    a_r7_reset_clears: assert property (@(posedge clk) disable iff (strobe.clearOut)
      clearSeen |-> product == '0);
  end else begin : g_comb
    assign product = arraySum;
  end

  // R2: the most negative value squared lands exactly on bit W-2.
  a_r2_min_squared: assert property (@(posedge clk) disable iff (strobe.clearOut)
    (opA == MIN_VAL && opB == MIN_VAL) |-> arraySum == MIN_SQ);

  // R3: the sign of a nonzero product is the XOR of the operand signs.
  a_r3_sign_rule: assert property (@(posedge clk) disable iff (strobe.clearOut)
    (opA != '0 && opB != '0) |-> arraySum[W-1] == (opA[N-1] ^ opB[N-1]));

  // R4: a zero operand gives a zero product.
  a_r4_zero_operand: assert property (@(posedge clk) disable iff (strobe.clearOut)
    (opA == '0 || opB == '0) |-> arraySum == '0);
endmodule

// File: rtl/bw_mult.sv
`timescale 1ns/1ps
module bw_mult
  import bw_mult_pkg::*;
#(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;

  outStrobe_t strobe;

  bw_ctrl u_ctrl (
    .rst   (rst),
    .strobe(strobe)
  );

  bw_datapath #(.N(N), .REG_OUT(REG_OUT)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );

  // Reference product, used only by the assertions.
  logic signed [W-1:0] refProd;
  assign refProd = $signed({{N{opA[N-1]}}, opA}) * $signed({{N{opB[N-1]}}, opB});

  logic pastValid;
  always_ff @(posedge clk) pastValid <= ~rst;

  if (REG_OUT) begin : g_chk_reg
    // R1 and R6: the registered product matches the operands one edge earlier.
    a_r6_one_edge: assert property (@(posedge clk) disable iff (rst)
      pastValid |-> $signed(product) == $past(refProd));
  end else begin : g_chk_comb
    // R1 and R8: the combinational product matches the current operands.
    a_r8_comb_product: assert property (@(posedge clk) disable iff (rst)
      $signed(product) == refProd);
  end
endmodule

// File: tb/sim_bw_mult.sv
`timescale 1ns/1ps
module sim_bw_mult;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [7:0]  a8, b8;
  logic [15:0] p8;

  bw_mult #(.N(4), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .opA(a4), .opB(b4), .product(p4));
  bw_mult #(.N(8), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst(rst), .opA(a8), .opB(b8), .product(p8));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] exp4(input logic [3:0] x, input logic [3:0] y);
    int sx = $signed(x);
    int sy = $signed(y);
    int pr = sx * sy;
    return pr[7:0];
  endfunction

  function automatic logic [15:0] exp8(input logic [7:0] x, input logic [7:0] y);
    int sx = $signed(x);
    int sy = $signed(y);
    int pr = sx * sy;
    return pr[15:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    a8 = x; b8 = y;
    #1;
  endtask

  initial begin
    logic [7:0] prev4;
    logic [7:0] neg;
    void'($urandom(32'd2718));
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset state", 16'(p4), 16'h0000);
    rst = 1'b0;
    prev4 = 8'h00;

    // R1/R6: exhaustive 4-bit sweep; random 8-bit vectors on the comb instance.
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        @(negedge clk);
        a4 = 4'(ia); b4 = 4'(ib);
        a8 = 8'($urandom); b8 = 8'($urandom);
        #1;
        chk("R6 hold between edges", 16'(p4), 16'(prev4));
        chk("R1 8-bit random", p8, exp8(a8, b8));
        @(negedge clk);
        chk("R1 4-bit exhaustive", 16'(p4), 16'(exp4(a4, b4)));
        prev4 = exp4(a4, b4);
      end
    end

    // R2: most negative squared.
    @(negedge clk); a4 = 4'h8; b4 = 4'h8;
    @(negedge clk); chk("R2 4-bit min squared", 16'(p4), 16'h0040);
    drive8(8'h80, 8'h80); chk("R2 8-bit min squared", p8, 16'h4000);

    // R3: sign rule on random nonzero operands.
    for (int k = 0; k < 60; k++) begin
      logic [7:0] x, y;
      x = 8'($urandom); y = 8'($urandom);
      if (x == 0) x = 8'h01;
      if (y == 0) y = 8'hF3;
      drive8(x, y);
      chk("R3 sign rule", 16'(p8[15]), 16'(x[7] ^ y[7]));
    end
    drive8(8'h7F, 8'h80); chk("R3 max times min", p8, 16'hC080);
    drive8(8'h7F, 8'h7F); chk("R1 max squared", p8, 16'h3F01);

    // R4: zero operands.
    drive8(8'h00, 8'h80); chk("R4 zero times min", p8, 16'h0000);
    drive8(8'hA5, 8'h00); chk("R4 value times zero", p8, 16'h0000);
    @(negedge clk); a4 = 4'h0; b4 = 4'h9;
    @(negedge clk); chk("R4 4-bit zero operand", 16'(p4), 16'h0000);

    // R5: multiplication by -1.
    drive8(8'h80, 8'hFF); chk("R5 min times minus one", p8, 16'h0080);
    drive8(8'hFF, 8'hFF); chk("R5 minus one squared", p8, 16'h0001);
    for (int k = 0; k < 20; k++) begin
      logic [7:0] x;
      x = 8'($urandom);
      neg = ~x;
      drive8(x, 8'hFF);
      chk("R5 negation", p8, 16'(~{{8{x[7]}}, x} + 16'h0001));
    end

    // R7/R8: reset clears the register, leaves the comb instance alone.
    @(negedge clk); a4 = 4'h3; b4 = 4'h5; a8 = 8'hF6; b8 = 8'h0D;
    @(negedge clk); chk("R6 capture before reset", 16'(p4), 16'h000F);
    rst = 1'b1;
    #1; chk("R7 synchronous, not yet cleared", 16'(p4), 16'h000F);
    chk("R8 reset ignored", p8, 16'hFF7E);
    @(negedge clk); chk("R7 cleared", 16'(p4), 16'h0000);
    @(negedge clk); chk("R7 held clear", 16'(p4), 16'h0000);
    b8 = 8'h81; #1;
    chk("R8 follows inputs in reset", p8, exp8(8'hF6, 8'h81));
    rst = 1'b0;
    @(negedge clk); chk("R7 resumes after reset", 16'(p4), 16'h000F);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule